// File: doc/BRIEF.md
# Bit-Order Reversing Half-Duplex Serial Bridge

This block sits between a host port that handles bytes least-significant bit first and a serial converter that shifts most-significant bit first. Both directions share a single data wire. The host asks for one byte transfer at a time through a byte-wide parallel port. A write strobe sends a byte and a read request fetches one. The bridge reverses the bit order on the way out and again on the way back. The host therefore never has to reorder bits itself.

On the device side the bridge makes a serial clock that rests high. It drives data on the falling edge and samples it on the rising edge. Its data driver is enabled only during a write, so an external pull-up holds the line at other times and the converter can drive it. The driver turns on and off only while the clock is high. The serial clock is divided down from the system clock and is kept at or below a configured maximum rate. Chip select can be produced as an active-low output, or tied low when the converter's select pin is wired permanently active. A 16-bit word is read as two transfers issued back to back.

Top module: `bitrev_serial_bridge`

## Requirements
- R1: During and after reset, sclk is 1, sd_oe is 0, busy is 0, done is 0, cs_n is 1 and rd_byte is 0.
- R2: sclk is 1 in every cycle in which busy is 0.
- R3: sd_oe is 1 throughout a write transfer. It is 0 throughout a read transfer and while idle.
- R4: A write places wr_byte[0] on the line at the first sclk rising edge, wr_byte[1] at the second, and so on up to wr_byte[7] at the eighth. The line is stable while sclk is high.
- R5: On a read, the bit sampled at the k-th sclk rising edge (k = 0..7) appears in rd_byte[k]. rd_byte holds that value from the cycle in which done is 1 until the next read completes.
- R6: Each transfer has exactly eight sclk rising edges.
- R7: Each sclk low phase lasts HALF = ceil(CLK_HZ / (2*SCLK_MAX_HZ)) system cycles. This is 17 for the defaults, giving a serial clock of no more than 3 MHz.
- R8: sd_oe changes only in cycles where sclk is 1 both before and after the change.
- R9: busy is 1 in the cycle after an accepted request. done is a one-cycle pulse that coincides with busy returning to 0.
- R10: wr_strobe and rd_req have no effect while busy is 1.
- R11: If wr_strobe and rd_req are both 1 in the same idle cycle, the write is performed.
- R12: With USE_CS=1, cs_n is 0 exactly while busy is 1.
- R13: A request in the first idle cycle after done starts the next transfer without any gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_strobe | input | 1 | Start a write of wr_byte |
| wr_byte | input | 8 | Host byte to send; bit 0 goes out first |
| rd_req | input | 1 | Start a read |
| rd_byte | output | 8 | Last byte read; bit 0 is the first bit received |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when a transfer ends |
| sclk | output | 1 | Serial clock, rests high |
| sd_out | output | 1 | Value driven onto the shared data line |
| sd_oe | output | 1 | Enable for the data line driver |
| sd_in | input | 1 | Value read from the shared data line |
| cs_n | output | 1 | Active-low chip select (tied 0 when USE_CS=0) |

## Verification
The assertions assume that sd_in is the resolved value of the shared line. That is sd_out while sd_oe is 1, and otherwise whatever the converter or the pull-up puts there. They also assume that host requests arrive only as level inputs sampled at the system clock. The bench builds sd_in in exactly that way from its converter model. The model changes its bit only on sclk falling edges, and it releases the line to 1 when it is not driving. All host inputs change on the inactive clock edge. Requests issued during a transfer, and both requests raised at once, are applied on purpose to test R10 and R11. They never violate the line-resolution assumption.

// File: rtl/bsb_pkg.sv
// Package: shared types for the bit-order reversing serial bridge.
// Assumes: nothing beyond IEEE 1800-2017.
package bsb_pkg;
    // Phases of one byte transfer on the serial side
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // line released, clock resting high
        PH_LEAD = 2'd1,   // clock high, driver direction settled
        PH_LOW  = 2'd2,   // clock low, data changes here
        PH_HIGH = 2'd3    // clock high, data sampled at entry
    } phase_t;
endpackage

// File: rtl/bsb_bitrev.sv
// Module: bsb_bitrev - pure wiring that mirrors a bus end for end.
// Assumes: W >= 1; purely combinational, no timing impact.
module bsb_bitrev #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    // One wire per bit, index mirrored
    for (genvar i = 0; i < W; i++) begin : g_mirror
        assign dout[i] = din[W-1-i];
    end
endmodule

// File: rtl/bsb_phase_timer.sv
// Module: bsb_phase_timer - counts system cycles of one half serial period.
// Assumes: HALF >= 2; counter is held at zero while run is low so the
//          first phase after a start is a full HALF cycles long.
module bsb_phase_timer #(
    parameter int HALF = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(HALF + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    // Cycle counter that wraps at the end of each half period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/bsb_engine.sv
// Module: bsb_engine - MSB-first byte shifter for a shared data wire.
// Assumes: tx_bits is already in line order (bit W-1 first); tick marks the
//          last cycle of each half period; sd_in is the resolved line value.
module bsb_engine
    import bsb_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_strobe,
    input  logic [W-1:0] tx_bits,
    input  logic         rd_req,
    input  logic         tick,
    input  logic         sd_in,
    output logic         run,
    output logic         busy,
    output logic         done,
    output logic         sclk,
    output logic         sd_out,
    output logic         sd_oe,
    output logic [W-1:0] rx_bits
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);

    phase_t        phase;
    logic [CW-1:0] bit_idx;
    logic [W-1:0]  shreg;
    logic          is_write;

    // Transfer sequencer: start, clock phases, shifting and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            bit_idx  <= '0;
            shreg    <= '0;
            is_write <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
            sclk     <= 1'b1;
            sd_oe    <= 1'b0;
            rx_bits  <= '0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (wr_strobe) begin
                        phase    <= PH_LEAD;
                        is_write <= 1'b1;
                        shreg    <= tx_bits;
                        sd_oe    <= 1'b1;
                        busy     <= 1'b1;
                        bit_idx  <= '0;
                    end else if (rd_req) begin
                        phase    <= PH_LEAD;
                        is_write <= 1'b0;
                        shreg    <= '0;
                        busy     <= 1'b1;
                        bit_idx  <= '0;
                    end
                end
                PH_LEAD: begin
                    if (tick) begin
                        phase <= PH_LOW;
                        sclk  <= 1'b0;
                    end
                end
                PH_LOW: begin
                    if (tick) begin
                        phase <= PH_HIGH;
                        sclk  <= 1'b1;
                        if (!is_write) begin
                            shreg <= {shreg[W-2:0], sd_in};
                        end
                    end
                end
                PH_HIGH: begin
                    if (tick) begin
                        if (bit_idx == LAST_BIT) begin
                            phase <= PH_IDLE;
                            busy  <= 1'b0;
                            done  <= 1'b1;
                            sd_oe <= 1'b0;
                            if (!is_write) begin
                                rx_bits <= shreg;
                            end
                        end else begin
                            phase   <= PH_LOW;
                            sclk    <= 1'b0;
                            bit_idx <= bit_idx + 1'b1;
                            if (is_write) begin
                                shreg <= {shreg[W-2:0], 1'b0};
                            end
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign run    = (phase != PH_IDLE);
    assign sd_out = shreg[W-1];
endmodule

// File: rtl/bitrev_serial_bridge.sv
// Module: bitrev_serial_bridge - host byte port (LSB first) to a serial
//         converter (MSB first) over one shared, tri-stated data wire.
// Assumes: CLK_HZ and SCLK_MAX_HZ are positive; the pad combines sd_out and
//          sd_oe with an external pull-up and returns the line on sd_in.
module bitrev_serial_bridge #(
    parameter int CLK_HZ      = 100_000_000,
    parameter int SCLK_MAX_HZ = 3_000_000,
    parameter int DATA_W      = 8,
    parameter bit USE_CS      = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_byte,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              sd_out,
    output logic              sd_oe,
    input  logic              sd_in,
    output logic              cs_n
);
    localparam int HALF_RAW = (CLK_HZ + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);
    localparam int HALF     = (HALF_RAW < 2) ? 2 : HALF_RAW;

    logic [DATA_W-1:0] tx_bits;
    logic [DATA_W-1:0] rx_bits;
    logic              run;
    logic              tick;

    // Host order to line order on the way out
    bsb_bitrev #(.W(DATA_W)) u_tx_rev (.din(wr_byte), .dout(tx_bits));

    // Line order back to host order on the way in
    bsb_bitrev #(.W(DATA_W)) u_rx_rev (.din(rx_bits), .dout(rd_byte));

    // Half-period timing for the serial clock
    bsb_phase_timer #(.HALF(HALF)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    // Byte sequencer and shared-line control
    bsb_engine #(.W(DATA_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_strobe (wr_strobe),
        .tx_bits   (tx_bits),
        .rd_req    (rd_req),
        .tick      (tick),
        .sd_in     (sd_in),
        .run       (run),
        .busy      (busy),
        .done      (done),
        .sclk      (sclk),
        .sd_out    (sd_out),
        .sd_oe     (sd_oe),
        .rx_bits   (rx_bits)
    );

    // Chip select: follows the transfer, or tied active when unused
    if (USE_CS) begin : g_cs
        assign cs_n = ~busy;
    end else begin : g_no_cs
        assign cs_n = 1'b0;
    end
endmodule

// File: rtl/bsb_checker.sv
// Module: bsb_checker - protocol properties of the serial bridge ports.
// Assumes: bound to bitrev_serial_bridge; observes ports only.
module bsb_checker #(
    parameter int CLK_HZ      = 100_000_000,
    parameter int SCLK_MAX_HZ = 3_000_000,
    parameter int DATA_W      = 8
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic sclk,
    input logic sd_out,
    input logic sd_oe
);
    localparam int HALF_RAW = (CLK_HZ + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);
    localparam int HALF     = (HALF_RAW < 2) ? 2 : HALF_RAW;

    int   low_len;
    int   rise_cnt;
    logic sclk_q;

    // Length of the current low phase and rising edges per transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_len  <= 0;
            rise_cnt <= 0;
            sclk_q   <= 1'b1;
        end else begin
            sclk_q  <= sclk;
            low_len <= sclk ? 0 : low_len + 1;
            if (done)              rise_cnt <= 0;
            else if (sclk && !sclk_q) rise_cnt <= rise_cnt + 1;
        end
    end

    AST_IDLE_CLOCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> sclk); // R2
    AST_DRIVE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) sd_oe |-> busy); // R3
    AST_TURN_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (sd_oe != $past(sd_oe)) |-> (sclk && $past(sclk))); // R8
    AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (sclk && $past(sclk) && sd_oe && $past(sd_oe)) |-> $stable(sd_out)); // R4
    AST_LOW_PHASE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) (sclk && !sclk_q) |-> (low_len == HALF)); // R7
    AST_EDGES_PER_BYTE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (rise_cnt == DATA_W)); // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy))); // R9
endmodule

bind bitrev_serial_bridge bsb_checker #(
    .CLK_HZ      (CLK_HZ),
    .SCLK_MAX_HZ (SCLK_MAX_HZ),
    .DATA_W      (DATA_W)
) u_bsb_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .sclk   (sclk),
    .sd_out (sd_out),
    .sd_oe  (sd_oe)
);

// File: tb/tb_bitrev_serial_bridge.sv
module tb_bitrev_serial_bridge;
    localparam int HALF = 17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_strobe = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       rd_req = 1'b0;
    logic [7:0] rd_byte;
    logic       busy, done, sclk, sd_out, sd_oe, cs_n;
    logic       sd_in;
    logic       dev_drive = 1'b1;

    int checks = 0;
    int errors = 0;

    // Converter model state
    logic [7:0] cap;
    logic [7:0] dev_pat;
    int         rises = 0;
    int         dev_idx = 0;
    int         lowcnt = 0;
    logic       cur_wr = 1'b0;

    always #5 clk = ~clk;

    // Line resolution: bridge drives when enabled, else converter or pull-up
    assign sd_in = sd_oe ? sd_out : dev_drive;

    bitrev_serial_bridge dut (
        .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_byte(wr_byte),
        .rd_req(rd_req), .rd_byte(rd_byte), .busy(busy), .done(done),
        .sclk(sclk), .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in), .cs_n(cs_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Count system cycles with the serial clock low
    always @(negedge clk) if (sclk === 1'b0) lowcnt++;

    // Converter receive side: sample line on each rising serial edge
    always @(posedge sclk) begin
        if (busy === 1'b1) begin
            if (rises < 8) cap[rises] = sd_in;
            rises++;
            chk(sd_oe == cur_wr, "R3 driver enable vs direction", sd_oe, cur_wr);
            chk(cs_n == 1'b0, "R12 chip select active", cs_n, 0);
            chk(lowcnt == HALF, "R7 low phase length", lowcnt, HALF);
        end
        lowcnt = 0;
    end

    // Converter transmit side: present next bit on each falling serial edge
    always @(negedge sclk) begin
        if (busy === 1'b1 && !cur_wr) begin
            dev_drive = dev_pat[dev_idx];
            dev_idx++;
        end
    end

    // One transfer; mode 0 plain, 1 extra requests while busy, 2 both requests
    task automatic run_op(input bit is_wr, input logic [7:0] val, input int mode);
        int n;
        rises = 0; dev_idx = 0; cap = 8'h00; dev_pat = val; cur_wr = is_wr;
        wr_byte   = val;
        wr_strobe = is_wr;
        rd_req    = !is_wr || (mode == 2);
        @(negedge clk);
        wr_strobe = 1'b0; rd_req = 1'b0;
        chk(busy == 1'b1, "R9 busy after request", busy, 1);
        n = 0;
        while (done !== 1'b1) begin
            @(negedge clk);
            n++;
            if (mode == 1) begin
                wr_strobe = (n == 40); rd_req = (n == 40) || (n == 120);
                wr_byte   = (n == 40) ? 8'hFF : val;
            end
        end
        wr_strobe = 1'b0; rd_req = 1'b0;
        chk(busy == 1'b0, "R9 busy low with done", busy, 0);
        chk(rises == 8, "R6 rising edges per byte", rises, 8);
        if (is_wr) chk(cap == val, "R4 line bit order on write", cap, val);
        else       chk(rd_byte == val, "R5 read byte order", rd_byte, val);
        dev_drive = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", done, 0);
        chk(sclk == 1'b1, "R2 clock idles high", sclk, 1);
        chk(cs_n == 1'b1, "R12 chip select released", cs_n, 1);
    endtask

    // Vectors: {1=write/0=read, byte}. Reads: byte bit k is the k-th line bit.
    localparam logic [8:0] VEC [0:7] = '{
        {1'b1, 8'h01}, {1'b1, 8'h80}, {1'b1, 8'hA5}, {1'b1, 8'h3C},
        {1'b0, 8'h01}, {1'b0, 8'hC3}, {1'b0, 8'h5A}, {1'b0, 8'hFE}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sclk == 1'b1 && sd_oe == 1'b0, "R1 reset line state", {sclk, sd_oe}, 2'b10);
        chk(busy == 1'b0 && done == 1'b0, "R1 reset handshake", {busy, done}, 0);
        chk(cs_n == 1'b1 && rd_byte == 8'h00, "R1 reset cs and data", {cs_n, rd_byte}, 9'h100);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk; consecutive calls are back to back (R13)
        for (int v = 0; v < 8; v++) run_op(VEC[v][8], VEC[v][7:0], 0);

        // R10: requests during a write are ignored
        run_op(1'b1, 8'hA5, 1);
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R10 no queued transfer", busy, 0);
        chk(rd_byte == 8'hFE, "R10 read data untouched", rd_byte, 8'hFE);

        // R11: both requests in one cycle give a write
        run_op(1'b1, 8'h96, 2);
        chk(rd_byte == 8'hFE, "R11 no read performed", rd_byte, 8'hFE);

        // R13: 16-bit word as two reads with no gap
        run_op(1'b0, 8'h34, 0);
        run_op(1'b0, 8'h12, 0);
        chk(rd_byte == 8'h12, "R13 second byte of word", rd_byte, 8'h12);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule